// File: doc/BRIEF.md
# Importance-Sampling Posterior Estimator

This block turns a set of weighted samples into a discrete posterior distribution. Each sample carries a state index, drawn beforehand from the prior, and an unsigned 32-bit likelihood weight. Because the samples already follow the prior, the prior never appears as a factor. The posterior of a state is the share of the total likelihood carried by the samples that landed in that state. The result is a self-normalised weighted histogram.

A start pulse launches a run. The block requests the samples one per cycle from an on-chip sample memory, which registers both its address and its data. It adds each weight to a total and to the bin named by the sample's state. Once the last sample has been added, it divides every bin sum by the total with a sequential restoring divider. Each quotient is written as a fixed-point fraction to an output memory, in ascending bin order. A one-cycle done pulse then marks the output memory as valid. Idle and ready outputs give the status to the surrounding control.

Top module: `posterior_estimator`

## Requirements
- R1: After reset, `idle` is 1 and `ready`, `done`, `sampleRdEn` and `resWrEn` are 0.
- R2: A start pulse while idle causes read requests on addresses 0 up to `sampleCount`-1, one per cycle and in order. The memory returns `sampleState` (8-bit unsigned) and `sampleWeight` (32-bit unsigned) two cycles after each request. `ready` is high for exactly one cycle after the final request, and no further request follows it in that run.
- R3: The word written to output address b equals floor(S_b * 2^16 / T), zero-extended into the 32-bit `resData`. Here S_b is the sum of weights of samples whose state equals b, and T is the sum of weights of all in-range samples. The bins are written in the order 0, 1, ..., 15.
- R4: A sample whose state is 16 or above adds to neither a bin sum nor the total.
- R5: When T is zero (no samples, all weights zero, or all states out of range), every output word is 0.
- R6: The output writes come exactly 19 cycles apart (16 fraction bits + 3). `done` is high for one cycle, in the cycle right after the write to address 15.
- R7: `idle` is high only while waiting for start. A start pulse during a run is ignored.
- R8: Every run starts from cleared sums, so its results do not depend on earlier runs.
- R9: 4096 samples that all carry weight 0xFFFFFFFF and the same state accumulate without overflow. That state's posterior is 65536 and every other bin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| sampleCount | input | 13 | Number of samples for the run (at most 4096), taken at start |
| idle | output | 1 | High while waiting for start |
| ready | output | 1 | One-cycle pulse once the final read request has been issued |
| done | output | 1 | One-cycle pulse once all posteriors are written |
| sampleRdEn | output | 1 | Read request to the sample memory |
| sampleAddr | output | 12 | Sample memory address |
| sampleState | input | 8 | State index read from the sample memory |
| sampleWeight | input | 32 | Likelihood weight read from the sample memory |
| resWrEn | output | 1 | Write strobe to the output memory |
| resAddr | output | 4 | Output memory address (bin index) |
| resData | output | 32 | Posterior of the bin, 16 fraction bits |

## Verification
A read address is due in the cycle its request is raised. `ready` is due one cycle after the final request, and the data of a request is due two cycles later. The first posterior write follows the accumulation drain. After it, each bin is due exactly 19 cycles after the one before, and `done` exactly one cycle after bin 15. The bench counts clock edges and samples on the falling edge. A monitor compares each write against a queue of values precomputed from the sample memory contents, and measures the spacing between writes and the position of `done` against those cycle counts. It also checks the idle, ready and done levels in the cycles around each start.

// File: rtl/pe_pkg.sv
package pe_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAcc;
    logic rdEn;
    logic loadDiv;
    logic stepDiv;
    logic writeRes;
  } peStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_LOAD,
    ST_STEP,
    ST_WRITE,
    ST_DONE
  } peState_t;

endpackage

// File: rtl/pe_divider.sv
// Restoring divider, one quotient bit per step. The dividend must not exceed
// the divisor, so FRAC+1 steps yield floor(dividend * 2^FRAC / divisor).
module pe_divider #(
  parameter int ACC_W = 44,
  parameter int FRAC  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [ACC_W-1:0] dividendIn,
  input  logic [ACC_W-1:0] divisor,
  output logic [FRAC:0]    quot
);

  logic [ACC_W:0] rem;
  logic [ACC_W:0] divExt;
  logic [ACC_W:0] diff;
  logic [ACC_W:0] remSel;
  logic           ge;

  assign divExt = {1'b0, divisor};
  assign ge     = rem >= divExt;
  assign diff   = rem - divExt;
  assign remSel = ge ? diff : rem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      quot <= '0;
    end else if (load) begin
      rem  <= {1'b0, dividendIn};
      quot <= '0;
    end else if (step) begin
      rem  <= remSel << 1;
      quot <= {quot[FRAC-1:0], ge};
    end
  end

endmodule

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int N_BINS  = 16,
  parameter int W_W     = 32,
  parameter int ST_W    = 8,
  parameter int ACC_W   = 44,
  parameter int FRAC    = 16,
  parameter int RES_W   = 32,
  parameter int MEM_LAT = 2,
  localparam int BIN_W  = $clog2(N_BINS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  peStrobes_t       st,
  input  logic [BIN_W-1:0] binSel,
  input  logic [ST_W-1:0]  sampleState,
  input  logic [W_W-1:0]   sampleWeight,
  output logic             pipeBusy,
  output logic [RES_W-1:0] resData
);

  localparam logic [ST_W:0] BINS_EXT = (ST_W+1)'(N_BINS);
  localparam logic [RES_W-1:0] ONE_FIX = RES_W'(1) << FRAC;

  logic [MEM_LAT-1:0] vPipe;
  logic               dataValid;
  logic               inRange;
  logic [ACC_W-1:0]   totalAcc;
  logic [ACC_W-1:0]   binAcc [N_BINS];
  logic [ACC_W-1:0]   selSum;
  logic [FRAC:0]      quot;
  logic               totalZero;

  // valid tag follows each request through the memory latency
  generate
    if (MEM_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vPipe <= '0;
        else       vPipe <= st.rdEn;
      end
    end else begin : g_latn
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vPipe <= '0;
        else       vPipe <= {vPipe[MEM_LAT-2:0], st.rdEn};
      end
    end
  endgenerate

  assign dataValid = vPipe[MEM_LAT-1];
  assign pipeBusy  = |vPipe;
  assign inRange   = {1'b0, sampleState} < BINS_EXT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     totalAcc <= '0;
    else if (st.clearAcc)          totalAcc <= '0;
    else if (dataValid && inRange) totalAcc <= totalAcc + ACC_W'(sampleWeight);
  end

  generate
    for (genvar g = 0; g < N_BINS; g++) begin : g_bin
      logic hit;
      assign hit = dataValid && inRange && (sampleState == ST_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            binAcc[g] <= '0;
        else if (st.clearAcc) binAcc[g] <= '0;
        else if (hit)         binAcc[g] <= binAcc[g] + ACC_W'(sampleWeight);
      end

      // R3
      bin_le_total_chk: assert property (@(posedge clk) disable iff (!rstN)
        binAcc[g] <= totalAcc);
    end
  endgenerate

  assign selSum    = binAcc[binSel];
  assign totalZero = (totalAcc == '0);

  pe_divider #(
    .ACC_W(ACC_W),
    .FRAC (FRAC)
  ) u_div (
    .clk       (clk),
    .rstN      (rstN),
    .load      (st.loadDiv),
    .step      (st.stepDiv),
    .dividendIn(selSum),
    .divisor   (totalAcc),
    .quot      (quot)
  );

  assign resData = totalZero ? '0 : RES_W'(quot);

  // R3
  quot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.writeRes |-> resData <= ONE_FIX);

endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int N_SAMPLES = 4096,
  parameter int N_BINS    = 16,
  parameter int FRAC      = 16,
  localparam int ADDR_W   = $clog2(N_SAMPLES),
  localparam int CNT_W    = $clog2(N_SAMPLES + 1),
  localparam int BIN_W    = $clog2(N_BINS),
  localparam int ITER_W   = $clog2(FRAC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  sampleCount,
  input  logic              pipeBusy,
  output peStrobes_t        st,
  output logic [ADDR_W-1:0] sampleAddr,
  output logic [BIN_W-1:0]  binSel,
  output logic              idle,
  output logic              ready,
  output logic              done
);

  localparam logic [BIN_W-1:0]  LAST_BIN  = BIN_W'(N_BINS - 1);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(FRAC);

  peState_t          state;
  peState_t          nextState;
  logic [CNT_W-1:0]  addrCnt;
  logic [CNT_W-1:0]  cntReg;
  logic [BIN_W-1:0]  binCnt;
  logic [ITER_W-1:0] iterCnt;

  always_comb begin
    nextState = state;
    st        = '0;
    idle      = 1'b0;
    ready     = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        idle = 1'b1;
        if (start) begin
          st.clearAcc = 1'b1;
          nextState   = ST_READ;
        end
      end
      ST_READ: begin
        if (addrCnt != cntReg) begin
          st.rdEn = 1'b1;
        end else begin
          ready     = 1'b1;
          nextState = ST_DRAIN;
        end
      end
      ST_DRAIN: if (!pipeBusy) nextState = ST_LOAD;
      ST_LOAD: begin
        st.loadDiv = 1'b1;
        nextState  = ST_STEP;
      end
      ST_STEP: begin
        st.stepDiv = 1'b1;
        if (iterCnt == LAST_ITER) nextState = ST_WRITE;
      end
      ST_WRITE: begin
        st.writeRes = 1'b1;
        nextState   = (binCnt == LAST_BIN) ? ST_DONE : ST_LOAD;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrCnt <= '0;
      cntReg  <= '0;
      binCnt  <= '0;
      iterCnt <= '0;
    end else begin
      state <= nextState;
      if (st.clearAcc) begin
        cntReg  <= sampleCount;
        addrCnt <= '0;
        binCnt  <= '0;
      end
      if (st.rdEn)     addrCnt <= addrCnt + 1'b1;
      if (st.loadDiv)  iterCnt <= '0;
      if (st.stepDiv)  iterCnt <= iterCnt + 1'b1;
      if (st.writeRes) binCnt  <= (binCnt == LAST_BIN) ? '0 : binCnt + 1'b1;
    end
  end

  assign sampleAddr = addrCnt[ADDR_W-1:0];
  assign binSel     = binCnt;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && $past(st.rdEn)) |-> sampleAddr == $past(sampleAddr) + 1'b1);

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !st.rdEn);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(st.writeRes) && $past(binSel) == LAST_BIN));

  // R7
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !$past(idle)) |-> $past(done));

endmodule

// File: rtl/posterior_estimator.sv
module posterior_estimator
  import pe_pkg::*;
#(
  parameter int N_SAMPLES = 4096,
  parameter int N_BINS    = 16,
  parameter int W_W       = 32,
  parameter int ST_W      = 8,
  parameter int FRAC      = 16,
  parameter int RES_W     = 32,
  parameter int MEM_LAT   = 2,
  localparam int ADDR_W   = $clog2(N_SAMPLES),
  localparam int CNT_W    = $clog2(N_SAMPLES + 1),
  localparam int BIN_W    = $clog2(N_BINS),
  localparam int ACC_W    = W_W + $clog2(N_SAMPLES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  sampleCount,
  output logic              idle,
  output logic              ready,
  output logic              done,
  output logic              sampleRdEn,
  output logic [ADDR_W-1:0] sampleAddr,
  input  logic [ST_W-1:0]   sampleState,
  input  logic [W_W-1:0]    sampleWeight,
  output logic              resWrEn,
  output logic [BIN_W-1:0]  resAddr,
  output logic [RES_W-1:0]  resData
);

  peStrobes_t       st;
  logic             pipeBusy;
  logic [BIN_W-1:0] binSel;

  pe_ctrl #(
    .N_SAMPLES(N_SAMPLES),
    .N_BINS   (N_BINS),
    .FRAC     (FRAC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleCount(sampleCount),
    .pipeBusy   (pipeBusy),
    .st         (st),
    .sampleAddr (sampleAddr),
    .binSel     (binSel),
    .idle       (idle),
    .ready      (ready),
    .done       (done)
  );

  pe_datapath #(
    .N_BINS (N_BINS),
    .W_W    (W_W),
    .ST_W   (ST_W),
    .ACC_W  (ACC_W),
    .FRAC   (FRAC),
    .RES_W  (RES_W),
    .MEM_LAT(MEM_LAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .binSel      (binSel),
    .sampleState (sampleState),
    .sampleWeight(sampleWeight),
    .pipeBusy    (pipeBusy),
    .resData     (resData)
  );

  assign sampleRdEn = st.rdEn;
  assign resWrEn    = st.writeRes;
  assign resAddr    = binSel;

endmodule

// File: tb/posterior_estimator_test.sv
`timescale 1ns/1ps
module posterior_estimator_test;

  localparam int N  = 4096;
  localparam int NB = 16;
  localparam int SW = 8;
  localparam int WW = 32;
  localparam int FR = 16;
  localparam int RW = 32;
  localparam int AW = 12;
  localparam int CW = 13;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] sampleCount = '0;
  logic          idle, ready, done, sampleRdEn, resWrEn;
  logic [AW-1:0] sampleAddr;
  logic [SW-1:0] sampleState = '0;
  logic [WW-1:0] sampleWeight = '0;
  logic [BW-1:0] resAddr;
  logic [RW-1:0] resData;

  logic [SW-1:0] memS [N];
  logic [WW-1:0] memW [N];
  logic [SW-1:0] rdS = '0;
  logic [WW-1:0] rdW = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int unsigned expQ[$];
  int expBin = 0;
  int lastWr = 0;
  bit haveWr = 0;
  int rdExp = 0;
  int curCount = 0;
  string curReq = "R3";

  always #2 clk = ~clk;

  posterior_estimator uut (
    .clk(clk), .rstN(rstN), .start(start), .sampleCount(sampleCount),
    .idle(idle), .ready(ready), .done(done),
    .sampleRdEn(sampleRdEn), .sampleAddr(sampleAddr),
    .sampleState(sampleState), .sampleWeight(sampleWeight),
    .resWrEn(resWrEn), .resAddr(resAddr), .resData(resData)
  );

  // sample memory: registered address stage, registered data stage
  always @(posedge clk) begin
    if (sampleRdEn) begin
      rdS <= memS[sampleAddr];
      rdW <= memW[sampleAddr];
    end
    sampleState  <= rdS;
    sampleWeight <= rdW;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // watchdog and cycle count
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor: reads, ready, writes (scoreboard), done
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleRdEn) begin
        check(sampleAddr == AW'(rdExp), "R2", "read address", sampleAddr, rdExp);
        rdExp++;
      end
      if (ready)
        check(rdExp == curCount, "R2", "reads before ready", rdExp, curCount);
      if (resWrEn) begin
        if (expQ.size() == 0) begin
          check(0, "R3", "unexpected write", resAddr, 0);
        end else begin
          int unsigned e;
          e = expQ.pop_front();
          check(resAddr == BW'(expBin), "R3", "bin address", resAddr, expBin);
          check(resData == e, curReq, "posterior", resData, e);
        end
        if (haveWr)
          check(cyc - lastWr == FR + 3, "R6", "write spacing", cyc - lastWr, FR + 3);
        lastWr = cyc;
        haveWr = 1;
        expBin++;
      end
      if (done) begin
        check(haveWr && (cyc - lastWr == 1), "R6", "done after last write", cyc - lastWr, 1);
        check(expQ.size() == 0 && expBin == NB, "R6", "bins written before done", expBin, NB);
      end
    end
  end

  // driver: compute expected posteriors, push them, run the block
  task automatic runCase(input int cnt, input string req, input bit poke);
    longint unsigned s [NB];
    longint unsigned total;
    total = 0;
    for (int b = 0; b < NB; b++) s[b] = 0;
    for (int i = 0; i < cnt; i++) begin
      if (memS[i] < NB) begin
        s[memS[i]] += longint'(memW[i]);
        total += longint'(memW[i]);
      end
    end
    for (int b = 0; b < NB; b++)
      expQ.push_back(total == 0 ? 0 : int'((s[b] << FR) / total));
    curReq   = req;
    curCount = cnt;
    rdExp    = 0;
    expBin   = 0;
    haveWr   = 0;
    @(negedge clk);
    sampleCount = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(idle == 1'b0, "R7", "idle during run", idle, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      sampleCount = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(idle == 1'b0, "R7", "idle after start while busy", idle, 0);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6", "done pulse width", done, 0);
    check(idle == 1'b1, "R7", "idle after done", idle, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic fillHand();
    int st [8] = '{0, 1, 1, 3, 2, 0, 15, 7};
    int wt [8] = '{100, 300, 200, 50, 350, 100, 400, 500};
    for (int i = 0; i < 8; i++) begin
      memS[i] = SW'(st[i]);
      memW[i] = WW'(wt[i]);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      memS[i] = '0;
      memW[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(idle == 1'b1, "R1", "idle after reset", idle, 1);
    check(ready == 1'b0, "R1", "ready after reset", ready, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(sampleRdEn == 1'b0, "R1", "read request after reset", sampleRdEn, 0);
    check(resWrEn == 1'b0, "R1", "write after reset", resWrEn, 0);

    // R3 hand-made set, all in range
    fillHand();
    runCase(8, "R3", 0);

    // R4 two samples out of range
    memS[3] = 8'd16;
    memS[6] = 8'd255;
    runCase(8, "R4", 0);

    // R5 no samples
    runCase(0, "R5", 0);

    // R5 all states out of range
    for (int i = 0; i < 10; i++) begin
      memS[i] = 8'd200;
      memW[i] = 32'd1000;
    end
    runCase(10, "R5", 0);

    // R5 all weights zero
    for (int i = 0; i < 10; i++) begin
      memS[i] = SW'(i);
      memW[i] = '0;
    end
    runCase(10, "R5", 0);

    // R9 full-scale weights, full count, one state
    for (int i = 0; i < N; i++) begin
      memS[i] = 8'd5;
      memW[i] = 32'hFFFF_FFFF;
    end
    runCase(N, "R9", 0);

    // R8 small set again after the large run
    for (int i = 0; i < N; i++) begin
      memS[i] = '0;
      memW[i] = '0;
    end
    fillHand();
    runCase(8, "R8", 0);

    // R7 random set with a start pulse during the run
    for (int i = 0; i < 300; i++) begin
      memS[i] = SW'($urandom_range(0, 19));
      memW[i] = $urandom;
    end
    runCase(300, "R7", 1);

    // R3 many small weights
    for (int i = 0; i < 1000; i++) begin
      memS[i] = SW'($urandom_range(0, 17));
      memW[i] = WW'($urandom_range(0, 1000));
    end
    runCase(1000, "R3", 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule